// File: doc/BRIEF.md
# Channel-Switch Settling Ready Gate

This block sits between a converter's conversion engine and its active-low data-ready line. It decides whether a freshly finished conversion may be announced as a valid sample. It watches three inputs: a multi-bit input-channel select, a speed-mode select and an internal/external source select. It also receives one pulse for each conversion the engine completes.

The block handles two kinds of disturbance in different ways.

- A change of the channel select forces the ready line high at once. The line then stays high for a fixed settling interval. The interval length depends on the speed mode, which is captured when the interval starts. Once the interval ends, the next result is valid and nothing needs to be thrown away.
- An abrupt input step works differently. It is reported either on a dedicated strobe or by a toggle of the source select. The ready line is not timed in this case. Instead, the next four conversion results are silently suppressed, and the fifth result is the first one flagged.

Both settling intervals are cycle-count parameters. Their defaults correspond to roughly 51 ms and 401 ms at a 4.9152 MHz converter clock. Scale them with the clock period for other frequencies.

Top module: `settle_ready_gate`

## Requirements
- R1: A change in any bit of `chan_sel` drives `ready_n` high in the same clock cycle that the new value is present on the input, before any clock edge.
- R2: The edge that captures a channel change starts a hold. `ready_n` stays high for exactly N further clock cycles, then goes low. N is `HOLD_FAST` when `speed_fast` is 1 at that edge, and `HOLD_SLOW` when it is 0.
- R3: `speed_fast` is sampled only at the edge that starts a hold. Changing it while a hold runs does not change when `ready_n` falls.
- R4: A channel change during a running hold restarts the full interval, counted from the edge that captures the new change.
- R5: After `step_flag` is high at a clock edge, the next four `conv_done` pulses give `sample_valid` = 0 and `ready_n` stays high. The fifth pulse gives `sample_valid` = 1.
- R6: A toggle of `src_int` is treated exactly like a `step_flag` pulse.
- R7: A new step while discards are still pending reloads the discard count to four.
- R8: When a step and `conv_done` are high in the same cycle, that result is judged against the state before the step. The four-result discard then starts with the following `conv_done`.
- R9: `sample_valid` equals `conv_done` whenever `ready_n` is low. No result is flagged while `ready_n` is high.
- R10: While `rst_n` is low, `ready_n` is high. In the first cycle after release, `ready_n` is low and no hold or discard is pending, whatever the current select values are.
- R11: A `conv_done` pulse during a channel hold is not flagged. The first `conv_done` after the hold ends is flagged, with no further discard.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_sel | input | SEL_W | Input-channel select |
| speed_fast | input | 1 | 1 = fast mode (short hold), 0 = slow mode (long hold) |
| src_int | input | 1 | Source select; a toggle counts as an input step |
| step_flag | input | 1 | Large input step indication |
| conv_done | input | 1 | One pulse per finished conversion |
| ready_n | output | 1 | Active-low ready line |
| sample_valid | output | 1 | Marks the current conv_done result as valid |

## Verification
The assertions assume the following about the inputs:

- All inputs are synchronous to `clk`.
- Every cycle in which `conv_done` is high counts as one finished conversion.
- A select value held across a clock edge is the value that edge captures.

The stimulus keeps within these assumptions:

- It changes inputs only just after the falling edge.
- It gives every `conv_done` and `step_flag` pulse exactly one rising edge.
- It never moves `chan_sel` in the middle of a cycle.

With these rules, hold lengths and discard counts can be counted edge by edge against the programmed values.

// File: rtl/settle_gate_pkg.sv
// Package: shared definitions for the settling ready gate.
// Assumes: nothing beyond standard SystemVerilog.
package settle_gate_pkg;
    typedef enum logic {
        SPD_SLOW = 1'b0,
        SPD_FAST = 1'b1
    } speed_e;

    // Number of results suppressed after an input step.
    localparam int unsigned STEP_DISCARDS = 4;
endpackage

// File: rtl/sel_change_det.sv
// Module: sel_change_det
// Flags, combinationally, any difference between a select bus and the
// value captured at the previous clock edge.
// Assumes: sel is synchronous to clk. During reset the stored copy tracks
// the input, so a released reset never reports a change.
module sel_change_det #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sel,
    output logic         changed
);
    logic [W-1:0] sel_q;
    logic [W-1:0] bit_diff;

    // Capture the select each cycle; reset tracks the input as well.
    always_ff @(posedge clk) begin
        sel_q <= sel;
    end

    // Per-bit comparison against the previous value.
    for (genvar gi = 0; gi < W; gi++) begin : g_bit
        assign bit_diff[gi] = sel[gi] ^ sel_q[gi];
    end

    // Reduce the per-bit differences to one flag, masked during reset.
    always_comb begin
        changed = rst_n && (bit_diff != '0);
    end
endmodule

// File: rtl/settle_hold_timer.sv
// Module: settle_hold_timer
// Down-counter holding a busy flag for a mode-dependent number of cycles.
// Assumes: load is a single-cycle or level request. The speed is sampled
// only on a load, and a load during a running count restarts it.
module settle_hold_timer #(
    parameter int unsigned HOLD_FAST = 250675,
    parameter int unsigned HOLD_SLOW = 1970995,
    parameter int unsigned CW        = 21
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic speed_fast,
    output logic busy
);
    import settle_gate_pkg::*;

    localparam logic [CW-1:0] FAST_C = CW'(HOLD_FAST);
    localparam logic [CW-1:0] SLOW_C = CW'(HOLD_SLOW);

    logic [CW-1:0] cnt;
    speed_e        spd;

    // Map the raw speed input onto the mode type.
    always_comb begin
        spd = speed_e'(speed_fast);
    end

    // Load on request, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (spd == SPD_FAST) ? FAST_C : SLOW_C;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Busy whenever any of the interval remains.
    always_comb begin
        busy = (cnt != '0);
    end

    // A load installs the interval of the speed present at that edge.
    p_load_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == ($past(speed_fast) ? FAST_C : SLOW_C)));

    // Without a load, a running count falls by exactly one per cycle.
    p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/step_discard_ctr.sv
// Module: step_discard_ctr
// Counts down the conversion results to drop after an input step.
// Assumes: every cycle with done high is one finished conversion. A step
// in the same cycle as done reloads the count and does not consume it.
module step_discard_ctr #(
    parameter int unsigned DISC_N = 4,
    parameter int unsigned DW     = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic done,
    output logic pending
);
    localparam logic [DW-1:0] DISC_C = DW'(DISC_N);

    logic [DW-1:0] cnt;

    // Reload on a step, otherwise consume one per finished conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= DISC_C;
        end else if (done && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Discards remain while the count is non-zero.
    always_comb begin
        pending = (cnt != '0);
    end

    // A step always leaves exactly the full discard budget.
    p_step_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (cnt == DISC_C));

    // The count never exceeds its budget.
    p_disc_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= DISC_C);
endmodule

// File: rtl/settle_ready_gate.sv
// Module: settle_ready_gate (top)
// Gates the active-low ready line and the per-result valid flag.
// A channel change holds ready high for a timed interval. A step, or a
// source toggle, silently drops the next four results.
// Assumes: all inputs are synchronous to clk and reset is synchronous
// and active low.
module settle_ready_gate #(
    parameter int unsigned SEL_W     = 2,
    parameter int unsigned HOLD_FAST = 250675,
    parameter int unsigned HOLD_SLOW = 1970995
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] chan_sel,
    input  logic             speed_fast,
    input  logic             src_int,
    input  logic             step_flag,
    input  logic             conv_done,
    output logic             ready_n,
    output logic             sample_valid
);
    import settle_gate_pkg::*;

    localparam int unsigned HOLD_MAX = (HOLD_FAST > HOLD_SLOW) ? HOLD_FAST : HOLD_SLOW;
    localparam int unsigned CW       = $clog2(HOLD_MAX + 1);
    localparam int unsigned DW       = $clog2(STEP_DISCARDS + 1);

    logic chan_change;
    logic src_change;
    logic step_any;
    logic hold_busy;
    logic disc_pending;

    sel_change_det #(.W(SEL_W)) u_chan_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (chan_sel),
        .changed (chan_change)
    );

    sel_change_det #(.W(1)) u_src_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (src_int),
        .changed (src_change)
    );

    // A source toggle counts as an input step.
    always_comb begin
        step_any = step_flag | src_change;
    end

    settle_hold_timer #(
        .HOLD_FAST (HOLD_FAST),
        .HOLD_SLOW (HOLD_SLOW),
        .CW        (CW)
    ) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (chan_change),
        .speed_fast (speed_fast),
        .busy       (hold_busy)
    );

    step_discard_ctr #(
        .DISC_N (STEP_DISCARDS),
        .DW     (DW)
    ) u_disc (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step_any),
        .done    (conv_done),
        .pending (disc_pending)
    );

    // Ready is held high in reset, on a fresh change, during a hold and
    // while discards remain.
    always_comb begin
        ready_n = !rst_n || chan_change || hold_busy || disc_pending;
    end

    // A result is announced only while ready is low.
    always_comb begin
        sample_valid = conv_done && !ready_n;
    end

    // A detected channel change must leave the timer running next cycle.
    p_change_starts_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        chan_change |=> hold_busy);

    // A detected step must leave discards pending next cycle.
    p_step_starts_discard_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step_any |=> disc_pending);
endmodule

// File: tb/sim_settle_ready_gate.sv
module sim_settle_ready_gate;
    localparam int unsigned N_FAST = 20;
    localparam int unsigned N_SLOW = 45;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] chan_sel = 2'b00;
    logic       speed_fast = 1'b1;
    logic       src_int = 1'b0;
    logic       step_flag = 1'b0;
    logic       conv_done = 1'b0;
    logic       ready_n;
    logic       sample_valid;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    settle_ready_gate #(
        .SEL_W     (2),
        .HOLD_FAST (N_FAST),
        .HOLD_SLOW (N_SLOW)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .chan_sel     (chan_sel),
        .speed_fast   (speed_fast),
        .src_int      (src_int),
        .step_flag    (step_flag),
        .conv_done    (conv_done),
        .ready_n      (ready_n),
        .sample_valid (sample_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count consecutive falling-edge samples with ready_n high.
    task automatic count_high(output int n);
        n = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (ready_n) n++;
            else break;
        end
    endtask

    // One conv_done pulse spanning a single rising edge; returns valid.
    task automatic pulse_done(output bit v);
        @(negedge clk);
        conv_done = 1'b1;
        #1 v = sample_valid;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    // Issue five done pulses and check the discard pattern.
    task automatic five_dones(input string req);
        bit v;
        for (int k = 0; k < 5; k++) begin
            pulse_done(v);
            chk(v == (k == 4), req, v, (k == 4));
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        chan_sel = 2'b10;
        @(negedge clk);
        #1 chk(ready_n == 1'b1, "R10 ready high in reset", ready_n, 1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready_n == 1'b0, "R10 ready low after release", ready_n, 0);
    endtask

    task automatic t_hold(input bit spd, input int exp, input string req);
        int n;
        speed_fast = spd;
        @(negedge clk);
        chan_sel = chan_sel + 2'd1;
        #1 chk(ready_n == 1'b1, "R1 immediate high", ready_n, 1);
        count_high(n);
        chk(n == exp, req, n, exp);
    endtask

    task automatic t_speed_midhold;
        int n, m;
        speed_fast = 1'b1;
        @(negedge clk);
        chan_sel = chan_sel ^ 2'b01;
        n = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (ready_n) n++;
        end
        speed_fast = 1'b0;
        count_high(m);
        chk(n + m == N_FAST, "R3 speed ignored mid-hold", n + m, N_FAST);
    endtask

    task automatic t_reload;
        int n;
        speed_fast = 1'b1;
        @(negedge clk);
        chan_sel = chan_sel ^ 2'b10;
        for (int i = 0; i < 7; i++) @(negedge clk);
        chan_sel = chan_sel ^ 2'b01;
        #1 chk(ready_n == 1'b1, "R4 high on second change", ready_n, 1);
        count_high(n);
        chk(n == N_FAST, "R4 hold restarted", n, N_FAST);
    endtask

    task automatic t_done_in_hold;
        bit v;
        speed_fast = 1'b1;
        @(negedge clk);
        chan_sel = chan_sel + 2'd1;
        for (int i = 0; i < 3; i++) @(negedge clk);
        pulse_done(v);
        chk(v == 1'b0, "R11 done during hold suppressed", v, 0);
        for (int i = 0; i < N_FAST; i++) @(negedge clk);
        chk(ready_n == 1'b0, "R11 hold over", ready_n, 0);
        pulse_done(v);
        chk(v == 1'b1, "R9 first done after hold valid", v, 1);
    endtask

    task automatic t_step;
        @(negedge clk);
        step_flag = 1'b1;
        @(negedge clk);
        step_flag = 1'b0;
        chk(ready_n == 1'b1, "R5 ready high while discarding", ready_n, 1);
        five_dones("R5 four dropped then valid");
    endtask

    task automatic t_src;
        @(negedge clk);
        src_int = ~src_int;
        @(negedge clk);
        five_dones("R6 source toggle acts as step");
    endtask

    task automatic t_step_reload;
        bit v;
        @(negedge clk);
        step_flag = 1'b1;
        @(negedge clk);
        step_flag = 1'b0;
        pulse_done(v);
        pulse_done(v);
        @(negedge clk);
        step_flag = 1'b1;
        @(negedge clk);
        step_flag = 1'b0;
        five_dones("R7 second step reloads four");
    endtask

    task automatic t_step_with_done;
        bit v;
        @(negedge clk);
        step_flag = 1'b1;
        conv_done = 1'b1;
        #1 v = sample_valid;
        chk(v == 1'b1, "R8 coincident done judged before step", v, 1);
        @(negedge clk);
        step_flag = 1'b0;
        conv_done = 1'b0;
        five_dones("R8 discard starts after coincident done");
    endtask

    initial begin : wdog
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done_flag) disable wdog;
        end
        errors++;
        checks++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_hold(1'b1, N_FAST, "R2 fast hold length");
        t_hold(1'b0, N_SLOW, "R2 slow hold length");
        t_speed_midhold();
        t_reload();
        t_done_in_hold();
        t_step();
        t_src();
        t_step_reload();
        t_step_with_done();
        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule